// File: doc/BRIEF.md
# Configurable-Sense Interrupt Controller

This block gathers a set of interrupt request lines and drives two processor-facing outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). For every source, software chooses level or edge detection, the active polarity, and, for edge sources, whether one edge or both edges count. Detected events are held in a raw status vector. That vector is combined with a software trigger vector, masked by a per-source enable and steered to one of the two outputs by a per-source route bit.

Software reaches the controller through a word-addressed register port. Writes take effect on the clock edge where `bus_valid_i` and `bus_write_i` are both high. Read data is combinational from `bus_addr_i`. The upper half of the address space is a legacy window. It is not serviced, and any access to it only raises a sticky flag. The source request lines are sampled on every clock. The block provides no vector generation and no priority ordering between sources.

Top module: `sense_intc`

## Requirements
- R1: After reset, the enable, route, sense, dual-edge, trigger and raw status registers read 0, the polarity register reads all ones in the implemented bits, the legacy flag reads 0, and `irq_o` and `fiq_o` are low.
- R2: The word offsets are fixed as follows: status=0 (read only), enable=1, route=2, sense=3, dual-edge=4, polarity=5, trigger=6, edge-clear=7 (write only), legacy flag=8. A write to offsets 1 to 6 reads back the written data in bits [N_SRC-1:0].
- R3: When the sense bit of a source is 1 (level mode), its status bit is high one clock after the input reaches its active level and low one clock after it leaves it. Polarity 1 means active-high and polarity 0 means active-low.
- R4: In edge mode (sense 0) with dual-edge 0, polarity 1 latches status on a rising input and polarity 0 latches it on a falling input. The opposite edge and an unchanged input latch nothing.
- R5: In edge mode with dual-edge 1, both rising and falling input changes latch status, whatever the polarity.
- R6: A latched edge status bit stays set until a 1 is written to that bit at the edge-clear offset. If a new edge and the clear fall in the same cycle, the bit stays set.
- R7: A bit set in the trigger register makes the corresponding status bit read 1 and asserts that source toward the outputs.
- R8: A source whose enable bit is 0 never drives `irq_o` or `fiq_o`.
- R9: An enabled, asserted source drives `irq_o` when its route bit is 0 and `fiq_o` when it is 1, one clock after its status or trigger is set.
- R10: An access with address bit ADDR_W-1 set changes no register and reads 0. It sets the legacy flag (bit 0 at offset 8), which stays set until a 1 is written to bit 0 at offset 8.
- R11: Register bits at positions N_SRC and above read 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt request lines, synchronous to clk |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address; top bit selects the legacy window |
| bus_wdata_i | input | REG_W | Write data |
| bus_rdata_o | output | REG_W | Read data for bus_addr_i |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A new edge on a source and a software clear of that same status bit can arrive on one clock edge. The bench provokes this by moving a line from inactive to active in the same cycle as it writes the edge-clear offset with that bit. It then requires the status bit to read 1, and to read 0 only after a later clear with no edge. The bench also sweeps every combination of sense, dual-edge and polarity against all four before/after input levels, and all four enable/route pairs. The expected status and output values are computed arithmetically from those settings.

// File: rtl/sense_intc_pkg.sv
package sense_intc_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_ENABLE  = 4'd1;
  localparam logic [OFS_W-1:0] OFS_ROUTE   = 4'd2;
  localparam logic [OFS_W-1:0] OFS_SENSE   = 4'd3;
  localparam logic [OFS_W-1:0] OFS_DUAL    = 4'd4;
  localparam logic [OFS_W-1:0] OFS_POLAR   = 4'd5;
  localparam logic [OFS_W-1:0] OFS_SWTRIG  = 4'd6;
  localparam logic [OFS_W-1:0] OFS_ECLR    = 4'd7;
  localparam logic [OFS_W-1:0] OFS_LEGFLAG = 4'd8;
endpackage

// File: rtl/sense_intc_regs.sv
module sense_intc_regs
  import sense_intc_pkg::*;
#(
  parameter int N_SRC  = 51,
  parameter int REG_W  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic [N_SRC-1:0]  raw_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  route_o,
  output logic [N_SRC-1:0]  sense_o,
  output logic [N_SRC-1:0]  dual_o,
  output logic [N_SRC-1:0]  polar_o,
  output logic [N_SRC-1:0]  trig_o,
  output logic [N_SRC-1:0]  clr_o
);
  localparam int PAD_W = REG_W - N_SRC;
  localparam int MID_W = ADDR_W - 1 - OFS_W;

  logic [N_SRC-1:0] en_q, route_q, sense_q, dual_q, polar_q, trig_q;
  logic [N_SRC-1:0] en_d, route_d, sense_d, dual_d, polar_d, trig_d;
  logic             legflag_q, legflag_d;
  logic             legacy, in_window, wr_hit;
  logic [OFS_W-1:0] ofs;
  logic [N_SRC-1:0] wbits;
  logic             unused_wbits;

  assign legacy    = bus_addr_i[ADDR_W-1];
  assign in_window = !legacy && (bus_addr_i[ADDR_W-2:OFS_W] == {MID_W{1'b0}});
  assign ofs       = bus_addr_i[OFS_W-1:0];
  assign wr_hit    = bus_valid_i && bus_write_i && in_window;
  assign wbits     = bus_wdata_i[N_SRC-1:0];
  assign unused_wbits = ^bus_wdata_i[REG_W-1:N_SRC];

  always_comb begin
    en_d      = en_q;
    route_d   = route_q;
    sense_d   = sense_q;
    dual_d    = dual_q;
    polar_d   = polar_q;
    trig_d    = trig_q;
    legflag_d = legflag_q;
    clr_o     = '0;
    if (wr_hit) begin
      unique case (ofs)
        OFS_ENABLE:  en_d    = wbits;
        OFS_ROUTE:   route_d = wbits;
        OFS_SENSE:   sense_d = wbits;
        OFS_DUAL:    dual_d  = wbits;
        OFS_POLAR:   polar_d = wbits;
        OFS_SWTRIG:  trig_d  = wbits;
        OFS_ECLR:    clr_o   = wbits;
        OFS_LEGFLAG: if (bus_wdata_i[0]) legflag_d = 1'b0;
        default: ;
      endcase
    end
    if (bus_valid_i && legacy) legflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      route_q   <= '0;
      sense_q   <= '0;
      dual_q    <= '0;
      polar_q   <= '1;
      trig_q    <= '0;
      legflag_q <= 1'b0;
    end else begin
      en_q      <= en_d;
      route_q   <= route_d;
      sense_q   <= sense_d;
      dual_q    <= dual_d;
      polar_q   <= polar_d;
      trig_q    <= trig_d;
      legflag_q <= legflag_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (in_window) begin
      unique case (ofs)
        OFS_STATUS:  bus_rdata_o = {{PAD_W{1'b0}}, raw_i};
        OFS_ENABLE:  bus_rdata_o = {{PAD_W{1'b0}}, en_q};
        OFS_ROUTE:   bus_rdata_o = {{PAD_W{1'b0}}, route_q};
        OFS_SENSE:   bus_rdata_o = {{PAD_W{1'b0}}, sense_q};
        OFS_DUAL:    bus_rdata_o = {{PAD_W{1'b0}}, dual_q};
        OFS_POLAR:   bus_rdata_o = {{PAD_W{1'b0}}, polar_q};
        OFS_SWTRIG:  bus_rdata_o = {{PAD_W{1'b0}}, trig_q};
        OFS_LEGFLAG: bus_rdata_o = {{(REG_W-1){1'b0}}, legflag_q};
        default:     bus_rdata_o = '0;
      endcase
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;
  assign sense_o = sense_q;
  assign dual_o  = dual_q;
  assign polar_o = polar_q;
  assign trig_o  = trig_q;

  p_legacy_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && legacy) |=> ($stable(en_q) && $stable(route_q) && $stable(sense_q)
                                 && $stable(dual_q) && $stable(polar_q) && $stable(trig_q)));
  p_legacy_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && legacy) |=> legflag_q);
  p_legacy_rdzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> (bus_rdata_o == '0));
endmodule

// File: rtl/sense_intc_detect.sv
module sense_intc_detect #(
  parameter int N_SRC = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] sense_i,
  input  logic [N_SRC-1:0] dual_i,
  input  logic [N_SRC-1:0] polar_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] stat_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] stat_q, stat_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic rise, fall, hit, lvl;
    assign rise = src_i[i] & ~prev_q[i];
    assign fall = ~src_i[i] & prev_q[i];
    assign hit  = dual_i[i] ? (rise | fall) : (polar_i[i] ? rise : fall);
    assign lvl  = polar_i[i] ? src_i[i] : ~src_i[i];

    always_comb begin
      if (sense_i[i]) stat_d[i] = lvl;
      else            stat_d[i] = (stat_q[i] & ~clr_i[i]) | hit;
    end

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_i[i] && stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    p_level_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[i] && polar_i[i] && src_i[i]) |=> stat_q[i]);
    p_level_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[i] && !polar_i[i] && src_i[i]) |=> !stat_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= src_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/sense_intc_route.sv
module sense_intc_route #(
  parameter int N_SRC = 51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] route_i,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [N_SRC-1:0] live;
  logic irq_q, irq_d, fiq_q, fiq_d;

  assign live = raw_i & en_i;

  always_comb begin
    irq_d = |(live & ~route_i);
    fiq_d = |(live & route_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  p_quiet_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_i & en_i) == '0) |=> (!irq_o && !fiq_o));
  p_fast_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_i & en_i & route_i) != '0) |=> fiq_o);
  p_norm_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_i & en_i & ~route_i) != '0) |=> irq_o);
endmodule

// File: rtl/sense_intc.sv
module sense_intc #(
  parameter int N_SRC  = 51,
  parameter int REG_W  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_SRC-1:0] en, route, sense, dual, polar, trig, clr, stat, raw;

  assign raw = stat | trig;

  sense_intc_regs #(.N_SRC(N_SRC), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .raw_i(raw), .en_o(en), .route_o(route), .sense_o(sense), .dual_o(dual),
    .polar_o(polar), .trig_o(trig), .clr_o(clr)
  );

  sense_intc_detect #(.N_SRC(N_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .sense_i(sense), .dual_i(dual),
    .polar_i(polar), .clr_i(clr), .stat_o(stat)
  );

  sense_intc_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .en_i(en), .route_i(route),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  p_trig_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & ~stat) != '0) |-> (raw != stat));
endmodule

// File: tb/sense_intc_tb_top.sv
module sense_intc_tb_top;
  localparam int N  = 12;
  localparam int RW = 64;
  localparam int AW = 6;
  localparam logic [RW-1:0] MASK = (64'd1 << N) - 64'd1;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [RW-1:0] bus_wdata = '0;
  logic [RW-1:0] bus_rdata;
  logic irq, fiq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sense_intc #(.N_SRC(N), .REG_W(RW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid_i(bus_valid),
    .bus_write_i(bus_write), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [RW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [RW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [RW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(0, v); check("R1 status", v, '0);
    rd(1, v); check("R1 enable", v, '0);
    rd(2, v); check("R1 route", v, '0);
    rd(3, v); check("R1 sense", v, '0);
    rd(4, v); check("R1 dual", v, '0);
    rd(5, v); check("R1 polarity", v, MASK);
    rd(6, v); check("R1 trigger", v, '0);
    rd(8, v); check("R1 legacy flag", v, '0);
    check("R1 outputs", {62'd0, irq, fiq}, '0);

    // R2 / R11 readback with upper bits set
    for (int a = 1; a <= 6; a++) begin
      logic [RW-1:0] pat;
      pat = 64'hA5A5_F0F0_3C3C_0000 | RW'(a * 37);
      wr(AW'(a), pat);
      rd(AW'(a), v);
      check("R2 R11 readback", v, pat & MASK);
    end
    wr(6, '0); wr(1, '0); wr(2, '0);

    // R3 R4 R5 sweep: sense/dual/polarity x before/after level
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic sn, du, po, l0, l1, exp;
        sn = c[2]; du = c[1]; po = c[0]; l0 = p[1]; l1 = p[0];
        wr(3, RW'(sn) << S); wr(4, RW'(du) << S); wr(5, RW'(po) << S);
        wr(1, 64'd1 << S); wr(2, '0);
        src[S] = l0;
        repeat (3) @(negedge clk);
        wr(7, '1);
        src[S] = l1;
        @(negedge clk);
        if (sn) exp = po ? l1 : ~l1;
        else    exp = (l0 != l1) && (du || (po ? l1 : l0));
        rd(0, v);
        if (sn)      check("R3 level status", RW'(v[S]), RW'(exp));
        else if (du) check("R5 dual edge status", RW'(v[S]), RW'(exp));
        else         check("R4 single edge status", RW'(v[S]), RW'(exp));
        @(negedge clk);
        check("R9 irq follows status", RW'(irq), RW'(exp));
      end
    end

    // R6 edge latch, collision with clear
    src = '0;
    wr(3, '0); wr(4, '0); wr(5, MASK); wr(1, '0);
    repeat (2) @(negedge clk);
    wr(7, '1);
    @(negedge clk);
    src[S] = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 7; bus_wdata = 64'd1 << S;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(0, v); check("R6 edge beats clear", RW'(v[S]), 64'd1);
    src[S] = 1'b0;
    repeat (3) @(negedge clk);
    rd(0, v); check("R6 latched after input drop", RW'(v[S]), 64'd1);
    wr(7, 64'd1 << S);
    rd(0, v); check("R6 cleared", RW'(v[S]), 64'd0);

    // R7 R8 R9 trigger x enable x route
    for (int k = 0; k < 4; k++) begin
      logic e, r;
      e = k[1]; r = k[0];
      wr(1, RW'(e) << S); wr(2, RW'(r) << S);
      wr(6, 64'd1 << S);
      rd(0, v); check("R7 trigger in status", RW'(v[S]), 64'd1);
      @(negedge clk);
      check("R8 R9 irq", RW'(irq), RW'(e & ~r));
      check("R8 R9 fiq", RW'(fiq), RW'(e & r));
      wr(6, '0);
    end

    // R10 legacy window
    wr(1, 64'h3);
    wr(AW'(32 + 1), '1);
    rd(1, v); check("R10 enable untouched", v, 64'h3);
    rd(AW'(32 + 1), v); check("R10 legacy read zero", v, '0);
    rd(8, v); check("R10 flag set", v, 64'd1);
    wr(AW'(32 + 6), '0);
    rd(8, v); check("R10 flag sticky", v, 64'd1);
    wr(8, 64'd1);
    rd(8, v); check("R10 flag cleared", v, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule